// File: doc/BRIEF.md
# Two-Wire Indexed Block Control-Register Slave

This block is a serial slave on a two-wire open-drain bus. It holds a small file of 8-bit control bytes and presents every byte as a parallel output so that neighbouring control logic can use it directly. The bus clock and data lines are brought into a fast system clock domain through two-flop synchronizers. The slave never drives a line high: it only asks for a pull-down on the data line through an output-enable.

A host writes by addressing the slave, then giving a starting index, then a byte count, then that many data bytes. Each accepted data byte lands at the current index, and the index then steps forward. A host reads in two phases. First it writes only an index. It then issues a repeated start with the read address. The slave answers with a count byte, taken from a dedicated count register, and then streams data from the chosen index until the host refuses a byte. Bus start and stop conditions are recognised at any point in a byte and put the slave back into a known state.

Top module: `smbrb_top`

## Requirements
- R1: After reset the data-line pull-down is off, every register reads 0x00, and the count register at index 8 reads 0x10.
- R2: A first byte of 0xD4 (7-bit address 0x6A, bit 0 = 0 meaning write) or 0xD5 (bit 0 = 1 meaning read) is acknowledged by pulling the data line low during the ninth clock.
- R3: A first byte with any other 7-bit address is not acknowledged. Every following byte up to the next start or stop is also left unacknowledged, and no register changes.
- R4: In a write, the byte after the address is the start index (low 4 bits), and the next byte is the count X. The next X data bytes are stored at index, index+1, and so on. Each of these bytes is acknowledged, and each is stored only when its acknowledge begins.
- R5: The index advances by one after every data byte written or read, and wraps from 15 to 0.
- R6: Once X data bytes have been written, any further data byte is not acknowledged and is not stored.
- R7: After a write of an index, a repeated start, and 0xD5, the slave sends the value of register 8 first, most significant bit first. It then sends the registers starting at the written index.
- R8: When the host leaves the acknowledge bit high after a read byte, the slave releases the data line and sends nothing more until a new start.
- R9: A stop that arrives in the middle of a data byte discards that partial byte. Data bytes completed earlier in the same transfer stay stored.
- R10: The slave changes its pull-down only while the bus clock is low.
- R11: A start seen at any bit position makes the slave treat the next byte as an address byte.
- R12: A value written to index 8 becomes the count byte returned by later reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| regs_flat | output | 128 | Register file, byte i on bits [8i+7:8i] |

## Verification
The bench targets the points where a slave of this kind usually goes wrong:
- The index wrapping past 15, on both writes and reads. A slave that failed to wrap would write or return data from the wrong byte.
- A data byte beyond the declared count. A slave that ignored the count would acknowledge the byte and overwrite a neighbouring register.
- A stop in the middle of a byte. A slave that committed too early would store half a byte.
- A start in the middle of a byte, and an address that belongs to another device. A slave that got these wrong would misread the following byte, or would acknowledge traffic meant for someone else.
- The read path itself. The bench checks that the count byte comes before any data, that a new value in register 8 shows up as the returned count, and that a refused byte leaves the data line free for the host's stop.
- The timing of the pull-down. Every change of the pull-down is checked against the bus clock of the previous cycle.

// File: rtl/smbrb_pkg.sv
package smbrb_pkg;

    // Bit-level phase of the slave within the current byte slot
    typedef enum logic [2:0] {
        PH_IDLE,    // not addressed: watch only for start/stop
        PH_RX,      // shifting in eight bits from the host
        PH_SACK,    // slave holds the acknowledge low
        PH_TX,      // shifting out eight bits to the host
        PH_MACK,    // host acknowledge slot after a sent byte
        PH_MNEXT    // host acknowledged: load next byte at clock fall
    } phase_e;

    // Meaning of the byte currently being moved
    typedef enum logic [2:0] {
        RL_ADDR,
        RL_INDEX,
        RL_COUNT,
        RL_WDATA,
        RL_RCOUNT,
        RL_RDATA
    } role_e;

    // Synchronized line levels and the bus events derived from them
    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic [7:0] reg_reset_value(int idx, int cnt_idx, int cnt_rst);
        logic [7:0] v;
        v = (idx == cnt_idx) ? 8'(cnt_rst) : 8'h00;
        return v;
    endfunction

endpackage

// File: rtl/smbrb_line_sync.sv
module smbrb_line_sync
    import smbrb_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;
    logic              scl_now;
    logic              sda_now;

    // Idle bus is high on both lines, so the chain resets high
    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_prev <= scl_pipe[STAGES-1];
            sda_prev <= sda_pipe[STAGES-1];
        end
    end

    assign scl_now = scl_pipe[STAGES-1];
    assign sda_now = sda_pipe[STAGES-1];

    always_comb begin
        ev.scl      = scl_now;
        ev.sda      = sda_now;
        ev.scl_rise = scl_now & ~scl_prev;
        ev.scl_fall = ~scl_now & scl_prev;
        // data edges while the clock stays high mark frame boundaries
        ev.start    = scl_now & scl_prev & sda_prev & ~sda_now;
        ev.stop     = scl_now & scl_prev & ~sda_prev & sda_now;
    end

endmodule

// File: rtl/smbrb_regfile.sv
module smbrb_regfile
    import smbrb_pkg::*;
#(
    parameter int NUM_REGS    = 16,
    parameter int IDX_W       = 4,
    parameter int COUNT_IDX   = 8,
    parameter int COUNT_RESET = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [IDX_W-1:0]      waddr,
    input  logic [7:0]            wdata,
    input  logic [IDX_W-1:0]      raddr,
    output logic [7:0]            rdata,
    output logic [7:0]            count_q,
    output logic [NUM_REGS*8-1:0] regs_flat
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [7:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= reg_reset_value(g, COUNT_IDX, COUNT_RESET);
            end else if (we && (waddr == IDX_W'(g))) begin
                q <= wdata;
            end
        end
        assign regs_flat[g*8 +: 8] = q;
    end

    assign rdata   = regs_flat[{raddr, 3'b000} +: 8];
    assign count_q = regs_flat[COUNT_IDX*8 +: 8];

    // R4: contents move only on a write strobe
    p_hold_without_write_r4: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(regs_flat));

    // R4: a write strobe leaves its byte at the addressed slot
    p_write_lands_r4: assert property (@(posedge clk) disable iff (rst)
        we |=> (regs_flat[{$past(waddr), 3'b000} +: 8] == $past(wdata)));

endmodule

// File: rtl/smbrb_ctrl.sv
module smbrb_ctrl
    import smbrb_pkg::*;
#(
    parameter int         IDX_W      = 4,
    parameter logic [6:0] SLAVE_ADDR = 7'h6A
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_ev_t          ev,
    input  logic [7:0]       rd_data,
    input  logic [7:0]       count_val,
    output logic             sda_oe,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic [IDX_W-1:0] rd_idx
);

    localparam logic [3:0] BITS_PER_BYTE = 4'd8;
    localparam logic [3:0] LAST_TX_BIT   = 4'd7;

    phase_e           phase;
    role_e            role;
    logic [3:0]       bitcnt;
    logic [7:0]       rx_sh;
    logic [7:0]       tx_sh;
    logic [7:0]       remain;
    logic [IDX_W-1:0] idx;

    logic byte_done;
    logic addr_hit;
    logic accept;

    assign byte_done = (phase == PH_RX) && ev.scl_fall && (bitcnt == BITS_PER_BYTE);
    assign addr_hit  = (rx_sh[7:1] == SLAVE_ADDR);

    always_comb begin
        case (role)
            RL_ADDR:  accept = addr_hit;
            RL_INDEX: accept = 1'b1;
            RL_COUNT: accept = 1'b1;
            RL_WDATA: accept = (remain != 8'd0);
            default:  accept = 1'b0;
        endcase
    end

    // a data byte is committed at the clock fall that opens its acknowledge
    assign wr_en   = byte_done && (role == RL_WDATA) && accept;
    assign wr_idx  = idx;
    assign wr_data = rx_sh;
    assign rd_idx  = idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            role   <= RL_ADDR;
            bitcnt <= '0;
            rx_sh  <= '0;
            tx_sh  <= '0;
            remain <= '0;
            idx    <= '0;
            sda_oe <= 1'b0;
        end else if (ev.start) begin
            phase  <= PH_RX;
            role   <= RL_ADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else if (ev.stop) begin
            phase  <= PH_IDLE;
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else begin
            case (phase)
                PH_RX: begin
                    if (ev.scl_rise && (bitcnt != BITS_PER_BYTE)) begin
                        rx_sh  <= {rx_sh[6:0], ev.sda};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (byte_done) begin
                        bitcnt <= '0;
                        if (accept) begin
                            sda_oe <= 1'b1;
                            phase  <= PH_SACK;
                        end else begin
                            phase  <= PH_IDLE;
                        end
                        case (role)
                            RL_ADDR:  role <= rx_sh[0] ? RL_RCOUNT : RL_INDEX;
                            RL_INDEX: begin
                                idx  <= rx_sh[IDX_W-1:0];
                                role <= RL_COUNT;
                            end
                            RL_COUNT: begin
                                remain <= rx_sh;
                                role   <= RL_WDATA;
                            end
                            RL_WDATA: begin
                                if (accept) begin
                                    idx    <= idx + IDX_W'(1);
                                    remain <= remain - 8'd1;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
                PH_SACK: begin
                    if (ev.scl_fall) begin
                        if (role == RL_RCOUNT) begin
                            tx_sh  <= count_val;
                            sda_oe <= ~count_val[7];
                            phase  <= PH_TX;
                        end else begin
                            sda_oe <= 1'b0;
                            phase  <= PH_RX;
                        end
                    end
                end
                PH_TX: begin
                    if (ev.scl_fall) begin
                        if (bitcnt == LAST_TX_BIT) begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            phase  <= PH_MACK;
                        end else begin
                            sda_oe <= ~tx_sh[6];
                            tx_sh  <= {tx_sh[6:0], 1'b0};
                            bitcnt <= bitcnt + 4'd1;
                        end
                    end
                end
                PH_MACK: begin
                    if (ev.scl_rise) begin
                        phase <= ev.sda ? PH_IDLE : PH_MNEXT;
                    end
                end
                PH_MNEXT: begin
                    if (ev.scl_fall) begin
                        tx_sh  <= rd_data;
                        sda_oe <= ~rd_data[7];
                        idx    <= idx + IDX_W'(1);
                        role   <= RL_RDATA;
                        phase  <= PH_TX;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R3: an unaddressed slave never pulls the line
    p_idle_released_r3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |-> !sda_oe);

    // R10: the pull-down only moves while the synchronized clock is low
    p_oe_moves_scl_low_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !ev.scl);

    // R4: every stored data byte is followed by an acknowledge
    p_store_then_ack_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> sda_oe);

    // R11: a start always re-arms address reception
    p_start_rearms_r11: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (phase == PH_RX && role == RL_ADDR && bitcnt == 4'd0 && !sda_oe));

    // R8: a refused byte ends the read
    p_nack_ends_read_r8: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_MACK && ev.scl_rise && ev.sda && !ev.start && !ev.stop)
        |=> (phase == PH_IDLE && !sda_oe));

    // R5: the index steps by exactly one per stored byte, wrapping naturally
    p_index_steps_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (idx == $past(idx) + IDX_W'(1)));

endmodule

// File: rtl/smbrb_top.sv
module smbrb_top
    import smbrb_pkg::*;
#(
    parameter int         NUM_REGS    = 16,
    parameter int         COUNT_IDX   = 8,
    parameter int         COUNT_RESET = 16,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] SLAVE_ADDR  = 7'h6A
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] regs_flat
);

    localparam int IDX_W = $clog2(NUM_REGS);

    bus_ev_t          ev;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0]       wr_data;
    logic [IDX_W-1:0] rd_idx;
    logic [7:0]       rd_data;
    logic [7:0]       count_val;

    smbrb_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    smbrb_ctrl #(
        .IDX_W      (IDX_W),
        .SLAVE_ADDR (SLAVE_ADDR)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .rd_data   (rd_data),
        .count_val (count_val),
        .sda_oe    (sda_oe),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx    (rd_idx)
    );

    smbrb_regfile #(
        .NUM_REGS    (NUM_REGS),
        .IDX_W       (IDX_W),
        .COUNT_IDX   (COUNT_IDX),
        .COUNT_RESET (COUNT_RESET)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (wr_en),
        .waddr     (wr_idx),
        .wdata     (wr_data),
        .raddr     (rd_idx),
        .rdata     (rd_data),
        .count_q   (count_val),
        .regs_flat (regs_flat)
    );

endmodule

// File: tb/smbrb_top_tb_top.sv
module smbrb_top_tb_top;

    localparam int NR = 16;
    localparam int Q  = 4;   // quarter bus-bit, in system clocks

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            host_scl = 1'b1;
    logic            host_sda = 1'b1;
    logic            sda_oe;
    logic [NR*8-1:0] regs_flat;
    logic            sda_line;

    int vectors = 0;
    int miscompares = 0;
    logic [7:0] model [NR];

    assign sda_line = host_sda & ~sda_oe;

    always #2 clk = ~clk;

    smbrb_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (host_scl),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .regs_flat (regs_flat)
    );

    task automatic check(input bit ok, input string req,
                         input logic [NR*8-1:0] act, input logic [NR*8-1:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [NR*8-1:0] model_flat();
        logic [NR*8-1:0] r;
        for (int i = 0; i < NR; i++) r[i*8 +: 8] = model[i];
        return r;
    endfunction

    task automatic check_regs(input string req);
        check(regs_flat === model_flat(), req, regs_flat, model_flat());
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic bus_start();
        host_sda = 1'b1; tick(Q);
        host_scl = 1'b1; tick(Q);
        host_sda = 1'b0; tick(Q);
        host_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        host_sda = 1'b0; tick(Q);
        host_scl = 1'b1; tick(Q);
        host_sda = 1'b1; tick(Q);
    endtask

    task automatic bit_out(input logic b);
        host_sda = b;    tick(Q);
        host_scl = 1'b1; tick(2*Q);
        host_scl = 1'b0; tick(Q);
    endtask

    task automatic bit_in(output logic v);
        host_sda = 1'b1; tick(Q);
        host_scl = 1'b1; tick(Q);
        v = sda_line;    tick(Q);
        host_scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
        logic v;
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(v);
        check((!v) == exp_ack, req, NR*8'(!v), NR*8'(exp_ack));
    endtask

    task automatic read_byte(input bit refuse, input logic [7:0] exp, input string req);
        logic [7:0] got;
        logic v;
        for (int i = 7; i >= 0; i--) begin
            bit_in(v);
            got[i] = v;
        end
        bit_out(refuse);
        check(got === exp, req, NR*8'(got), NR*8'(exp));
    endtask

    // R10: every change of the pull-down must follow a low bus clock
    logic oe_q  = 1'b0;
    logic scl_q = 1'b1;
    always @(negedge clk) begin
        if (!rst) begin
            if (sda_oe !== oe_q) check(!scl_q, "R10", NR*8'(scl_q), '0);
        end
        oe_q  = sda_oe;
        scl_q = host_scl;
    end

    bit finished = 1'b0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NR; i++) model[i] = 8'h00;
        model[8] = 8'h10;
        tick(6);
        // R1: reset state
        check(sda_oe === 1'b0, "R1", NR*8'(sda_oe), '0);
        check_regs("R1");
        rst = 1'b0;
        tick(8);
        check(sda_oe === 1'b0, "R1", NR*8'(sda_oe), '0);

        // R2 R4: block write of four bytes from index 3
        bus_start();
        send_byte(8'hD4, 1'b1, "R2");
        send_byte(8'h03, 1'b1, "R4");
        send_byte(8'h04, 1'b1, "R4");
        send_byte(8'hA1, 1'b1, "R4");
        send_byte(8'hB2, 1'b1, "R4");
        send_byte(8'hC3, 1'b1, "R4");
        send_byte(8'hD4, 1'b1, "R4");
        bus_stop();
        model[3] = 8'hA1; model[4] = 8'hB2; model[5] = 8'hC3; model[6] = 8'hD4;
        check_regs("R4");

        // R5: write wraps from 15 to 0
        bus_start();
        send_byte(8'hD4, 1'b1, "R2");
        send_byte(8'h0E, 1'b1, "R5");
        send_byte(8'h03, 1'b1, "R5");
        send_byte(8'h11, 1'b1, "R5");
        send_byte(8'h22, 1'b1, "R5");
        send_byte(8'h33, 1'b1, "R5");
        bus_stop();
        model[14] = 8'h11; model[15] = 8'h22; model[0] = 8'h33;
        check_regs("R5");

        // R6: byte beyond the count is refused and not stored
        bus_start();
        send_byte(8'hD4, 1'b1, "R2");
        send_byte(8'h0A, 1'b1, "R6");
        send_byte(8'h01, 1'b1, "R6");
        send_byte(8'h5A, 1'b1, "R6");
        send_byte(8'h6B, 1'b0, "R6");
        bus_stop();
        model[10] = 8'h5A;
        check_regs("R6");

        // R7 R8: indexed read with count byte first
        bus_start();
        send_byte(8'hD4, 1'b1, "R7");
        send_byte(8'h03, 1'b1, "R7");
        bus_start();
        send_byte(8'hD5, 1'b1, "R2");
        read_byte(1'b0, 8'h10, "R7");
        read_byte(1'b0, 8'hA1, "R7");
        read_byte(1'b0, 8'hB2, "R7");
        read_byte(1'b0, 8'hC3, "R7");
        read_byte(1'b1, 8'hD4, "R8");
        tick(Q);
        check(sda_oe === 1'b0, "R8", NR*8'(sda_oe), '0);
        bus_stop();
        check_regs("R8");

        // R12: new count value, then read across the wrap (R5)
        bus_start();
        send_byte(8'hD4, 1'b1, "R12");
        send_byte(8'h08, 1'b1, "R12");
        send_byte(8'h01, 1'b1, "R12");
        send_byte(8'h02, 1'b1, "R12");
        bus_stop();
        model[8] = 8'h02;
        check_regs("R12");
        bus_start();
        send_byte(8'hD4, 1'b1, "R5");
        send_byte(8'h0F, 1'b1, "R5");
        bus_start();
        send_byte(8'hD5, 1'b1, "R2");
        read_byte(1'b0, 8'h02, "R12");
        read_byte(1'b0, 8'h22, "R5");
        read_byte(1'b1, 8'h33, "R5");
        bus_stop();

        // R3: foreign address, everything after it ignored
        bus_start();
        send_byte(8'hA0, 1'b0, "R3");
        send_byte(8'h03, 1'b0, "R3");
        send_byte(8'h01, 1'b0, "R3");
        send_byte(8'hFF, 1'b0, "R3");
        bus_stop();
        check_regs("R3");

        // R9: stop inside a data byte drops it, keeps earlier byte
        bus_start();
        send_byte(8'hD4, 1'b1, "R9");
        send_byte(8'h05, 1'b1, "R9");
        send_byte(8'h02, 1'b1, "R9");
        send_byte(8'h77, 1'b1, "R9");
        bit_out(1'b1); bit_out(1'b0); bit_out(1'b0); bit_out(1'b1);
        bus_stop();
        model[5] = 8'h77;
        check_regs("R9");

        // R11: start inside an address byte restarts addressing
        bus_start();
        bit_out(1'b1); bit_out(1'b1); bit_out(1'b0);
        bus_start();
        send_byte(8'hD4, 1'b1, "R11");
        send_byte(8'h09, 1'b1, "R11");
        send_byte(8'h01, 1'b1, "R11");
        send_byte(8'h3C, 1'b1, "R11");
        bus_stop();
        model[9] = 8'h3C;
        check_regs("R11");

        tick(10);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule